// File: doc/BRIEF.md
# Two-Lane First-Order Recursive Filter

This block runs the first-order recursion y[n] = x[n] + a·y[n-1] at two samples per clock. Each accepted cycle carries one sample pair. Lane 0 holds the even-indexed sample and lane 1 holds the odd-indexed sample of the stream. The block returns the two matching outputs a fixed number of cycles later. The result is the same as running the one-sample-per-cycle filter at twice the clock rate.

Unfolding the recursion directly would put two multiply-add pairs in series inside the loop. This block avoids that. It rewrites the odd output as x_odd + a·x_even + a²·y_odd_prev. The term x_odd + a·x_even does not depend on the fed-back state, so it is built in a registered forward path. The loop itself holds only the previous odd output, one multiply by the stored square a², and one add. The even output, x_even + a·y_odd_prev, reads the loop state but does not feed back into it.

The coefficient is a signed fixed-point value. It is loaded through a strobe, and its square is formed at load time and held in a register. A synchronous flush clears the recursion and drops any pairs still in the pipeline. The active-low asynchronous reset brings the whole block to a known idle state.

Top module: `iir2_par`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and y_even_o and y_odd_o are 0. Reset also sets the feedback state, the stored coefficient and its square to 0, so the first pair after reset passes through unchanged.
- R2: A pair is accepted on a rising edge where valid_i is high and flush_i is low. Its outputs appear with valid_o high in the cycle that follows the rising edge LAT-1 edges after the accepting edge, where LAT = 3 + FWD_EXTRA. valid_o stays high for that one cycle only.
- R3: The lane-0 output is y_even = x_even + a·y_odd_prev. Here y_odd_prev is the lane-1 output of the previously accepted pair, or 0 after reset or flush.
- R4: The lane-1 output equals the serial step taken after the even sample of the same pair: y_odd = x_odd + a·y_even.
- R5: Over any run of accepted pairs, the outputs equal the serial recurrence y[n] = x[n] + a·y[n-1] applied to the interleaved stream x_even, x_odd, x_even, .... Each product is formed as (a·v) shifted right arithmetically by FRAC_W. With the default FRAC_W = 0 the match is bit-exact.
- R6: A cycle with valid_i low produces no output and leaves the feedback state unchanged. The stream resumes as if the idle cycles were absent.
- R7: A rising edge with coef_load_i high stores coef_i as a signed COEF_W-bit value with FRAC_W fractional bits, together with its square. The new value applies to pairs accepted afterwards. The stored value does not change on any other edge, and loading a coefficient does not clear the feedback state.
- R8: A rising edge with flush_i high does four things: it discards every pair in flight, it discards any pair presented in that same cycle, it clears the feedback state to 0, and it leaves valid_o low in the following cycle.
- R9: All sums and products wrap modulo 2^DATA_W in two's complement. The block never saturates.
- R10: y_even_o and y_odd_o change only in cycles where valid_o is high. Otherwise they hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous clear of the recursion and the pipeline |
| coef_load_i | input | 1 | Strobe that stores coef_i |
| coef_i | input | COEF_W | Signed feedback coefficient, FRAC_W fractional bits |
| valid_i | input | 1 | Input pair valid |
| x_even_i | input | DATA_W | Even-indexed input sample (lane 0) |
| x_odd_i | input | DATA_W | Odd-indexed input sample (lane 1) |
| valid_o | output | 1 | Output pair valid |
| y_even_o | output | DATA_W | Even-indexed output sample (lane 0) |
| y_odd_o | output | DATA_W | Odd-indexed output sample (lane 1) |

## Verification
The block's only memory is the previous odd output, so any error in that state shows at the ports on the very next accepted pair. The even lane of that pair carries a·(error) and the odd lane carries a²·(error). After that the error keeps propagating through every later pair. A fault in the forward path, such as a wrong product, a lane swap or a missing stage, shows at once as a wrong odd value or a shifted valid_o cycle. The bench therefore compares every output pair against a serial model at the exact expected cycle. It also checks the cycle right after each flush, gap or coefficient load.

// File: rtl/iir2_pkg.sv
`timescale 1ns/1ps
package iir2_pkg;

  // register stages ahead of the loop (product, sum) and inside it
  localparam int unsigned FWD_BASE   = 2;
  localparam int unsigned LOOP_DEPTH = 1;

  function automatic int unsigned total_lat(input int unsigned extra);
    return FWD_BASE + extra + LOOP_DEPTH;
  endfunction

endpackage

// File: rtl/iir2_qmul.sv
`timescale 1ns/1ps
// signed multiply, arithmetic rescale by FRAC_W, wrap to OUT_W
module iir2_qmul #(
  parameter int unsigned A_W    = 8,
  parameter int unsigned B_W    = 16,
  parameter int unsigned FRAC_W = 0,
  parameter int unsigned OUT_W  = 16
) (
  input  logic signed [A_W-1:0]   a_i,
  input  logic signed [B_W-1:0]   b_i,
  output logic signed [OUT_W-1:0] p_o
);

  localparam int unsigned P_W = A_W + B_W;

  logic signed [P_W-1:0] full;
  logic signed [P_W-1:0] scaled;

  assign full   = a_i * b_i;
  assign scaled = full >>> FRAC_W;
  assign p_o    = scaled[OUT_W-1:0];

  generate
    if (P_W > OUT_W) begin : g_drop
      logic unused_hi;
      assign unused_hi = ^scaled[P_W-1:OUT_W];
    end
  endgenerate

endmodule

// File: rtl/iir2_coef_reg.sv
`timescale 1ns/1ps
module iir2_coef_reg #(
  parameter int unsigned COEF_W = 8,
  parameter int unsigned FRAC_W = 0,
  parameter int unsigned SQ_W   = 2 * COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [COEF_W-1:0] coef_o,
  output logic signed [SQ_W-1:0]   coef_sq_o
);

  logic signed [SQ_W-1:0] sq_next;

  // square formed from the incoming value so both registers update together
  iir2_qmul #(
    .A_W   (COEF_W),
    .B_W   (COEF_W),
    .FRAC_W(FRAC_W),
    .OUT_W (SQ_W)
  ) u_sq (
    .a_i(coef_i),
    .b_i(coef_i),
    .p_o(sq_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_o    <= '0;
      coef_sq_o <= '0;
    end else if (load_i) begin
      coef_o    <= coef_i;
      coef_sq_o <= sq_next;
    end
  end

endmodule

// File: rtl/iir2_fwd_path.sv
`timescale 1ns/1ps
// state-free terms: carries x_even and builds x_odd + a*x_even
module iir2_fwd_path #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned FRAC_W = 0,
  parameter int unsigned EXTRA  = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x_even_i,
  input  logic signed [DATA_W-1:0] x_odd_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] x_even_o,
  output logic signed [DATA_W-1:0] fwd_o
);

  logic signed [DATA_W-1:0] prod;

  iir2_qmul #(
    .A_W   (COEF_W),
    .B_W   (DATA_W),
    .FRAC_W(FRAC_W),
    .OUT_W (DATA_W)
  ) u_mul (
    .a_i(coef_i),
    .b_i(x_even_i),
    .p_o(prod)
  );

  // stage A: product
  logic                     v_a;
  logic signed [DATA_W-1:0] xe_a, xo_a, p_a;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_a  <= 1'b0;
      xe_a <= '0;
      xo_a <= '0;
      p_a  <= '0;
    end else begin
      v_a  <= valid_i & ~flush_i;
      xe_a <= x_even_i;
      xo_a <= x_odd_i;
      p_a  <= prod;
    end
  end

  // stage B: sum
  logic                     v_b;
  logic signed [DATA_W-1:0] xe_b, f_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_b  <= 1'b0;
      xe_b <= '0;
      f_b  <= '0;
    end else begin
      v_b  <= v_a & ~flush_i;
      xe_b <= xe_a;
      f_b  <= xo_a + p_a;
    end
  end

  generate
    if (EXTRA == 0) begin : g_direct
      assign valid_o  = v_b;
      assign x_even_o = xe_b;
      assign fwd_o    = f_b;
    end else begin : g_delay
      logic [EXTRA-1:0]             v_d;
      logic [EXTRA-1:0][DATA_W-1:0] xe_d;
      logic [EXTRA-1:0][DATA_W-1:0] f_d;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_d  <= '0;
          xe_d <= '0;
          f_d  <= '0;
        end else begin
          v_d[0]  <= v_b & ~flush_i;
          xe_d[0] <= xe_b;
          f_d[0]  <= f_b;
          for (int i = 1; i < EXTRA; i++) begin
            v_d[i]  <= v_d[i-1] & ~flush_i;
            xe_d[i] <= xe_d[i-1];
            f_d[i]  <= f_d[i-1];
          end
        end
      end

      assign valid_o  = v_d[EXTRA-1];
      assign x_even_o = $signed(xe_d[EXTRA-1]);
      assign fwd_o    = $signed(f_d[EXTRA-1]);
    end
  endgenerate

endmodule

// File: rtl/iir2_loop.sv
`timescale 1ns/1ps
// recursion: one multiply by a^2 and one add between state and state
module iir2_loop #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned FRAC_W = 0,
  parameter int unsigned SQ_W   = 2 * COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x_even_i,
  input  logic signed [DATA_W-1:0] fwd_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [SQ_W-1:0]   coef_sq_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] y_even_o,
  output logic signed [DATA_W-1:0] y_odd_o
);

  logic signed [DATA_W-1:0] state_q;
  logic signed [DATA_W-1:0] a_s, a2_s, nxt;

  iir2_qmul #(
    .A_W   (COEF_W),
    .B_W   (DATA_W),
    .FRAC_W(FRAC_W),
    .OUT_W (DATA_W)
  ) u_mul_a (
    .a_i(coef_i),
    .b_i(state_q),
    .p_o(a_s)
  );

  iir2_qmul #(
    .A_W   (SQ_W),
    .B_W   (DATA_W),
    .FRAC_W(FRAC_W),
    .OUT_W (DATA_W)
  ) u_mul_a2 (
    .a_i(coef_sq_i),
    .b_i(state_q),
    .p_o(a2_s)
  );

  assign nxt = fwd_i + a2_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= '0;
      valid_o  <= 1'b0;
      y_even_o <= '0;
      y_odd_o  <= '0;
    end else if (flush_i) begin
      state_q <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        state_q  <= nxt;
        y_even_o <= x_even_i + a_s;
        y_odd_o  <= nxt;
      end
    end
  end

endmodule

// File: rtl/iir2_par.sv
`timescale 1ns/1ps
module iir2_par #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned COEF_W    = 8,
  parameter int unsigned FRAC_W    = 0,
  parameter int unsigned FWD_EXTRA = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     coef_load_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x_even_i,
  input  logic signed [DATA_W-1:0] x_odd_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] y_even_o,
  output logic signed [DATA_W-1:0] y_odd_o
);

  localparam int unsigned SQ_W = 2 * COEF_W;
  localparam int unsigned LAT  = iir2_pkg::total_lat(FWD_EXTRA);

  logic signed [COEF_W-1:0] coef_q;
  logic signed [SQ_W-1:0]   coef_sq_q;
  logic                     fwd_valid;
  logic signed [DATA_W-1:0] fwd_xe, fwd_sum;

  iir2_coef_reg #(
    .COEF_W(COEF_W),
    .FRAC_W(FRAC_W),
    .SQ_W  (SQ_W)
  ) u_coef (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (coef_load_i),
    .coef_i   (coef_i),
    .coef_o   (coef_q),
    .coef_sq_o(coef_sq_q)
  );

  iir2_fwd_path #(
    .DATA_W(DATA_W),
    .COEF_W(COEF_W),
    .FRAC_W(FRAC_W),
    .EXTRA (FWD_EXTRA)
  ) u_fwd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .valid_i (valid_i),
    .x_even_i(x_even_i),
    .x_odd_i (x_odd_i),
    .coef_i  (coef_q),
    .valid_o (fwd_valid),
    .x_even_o(fwd_xe),
    .fwd_o   (fwd_sum)
  );

  iir2_loop #(
    .DATA_W(DATA_W),
    .COEF_W(COEF_W),
    .FRAC_W(FRAC_W),
    .SQ_W  (SQ_W)
  ) u_loop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .valid_i  (fwd_valid),
    .x_even_i (fwd_xe),
    .fwd_i    (fwd_sum),
    .coef_i   (coef_q),
    .coef_sq_i(coef_sq_q),
    .valid_o  (valid_o),
    .y_even_o (y_even_o),
    .y_odd_o  (y_odd_o)
  );

endmodule

// File: rtl/iir2_par_chk.sv
`timescale 1ns/1ps
module iir2_par_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned SQ_W   = 16,
  parameter int unsigned LAT    = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     flush_i,
  input logic                     coef_load_i,
  input logic signed [COEF_W-1:0] coef_i,
  input logic                     valid_i,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] y_even_o,
  input logic signed [DATA_W-1:0] y_odd_o,
  input logic signed [COEF_W-1:0] coef_q_i,
  input logic signed [SQ_W-1:0]   coef_sq_q_i
);

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o);

  a_r2_valid_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, LAT));

  a_r7_coef_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_load_i |=> coef_q_i == $past(coef_i));

  a_r7_coef_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !coef_load_i |=> $stable(coef_q_i) && $stable(coef_sq_q_i));

  a_r8_flush_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_o);

  a_r10_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(y_even_o) && $stable(y_odd_o));

endmodule

bind iir2_par iir2_par_chk #(
  .DATA_W(DATA_W),
  .COEF_W(COEF_W),
  .SQ_W  (SQ_W),
  .LAT   (LAT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flush_i    (flush_i),
  .coef_load_i(coef_load_i),
  .coef_i     (coef_i),
  .valid_i    (valid_i),
  .valid_o    (valid_o),
  .y_even_o   (y_even_o),
  .y_odd_o    (y_odd_o),
  .coef_q_i   (coef_q),
  .coef_sq_q_i(coef_sq_q)
);

// File: tb/iir2_par_tb.sv
`timescale 1ns/1ps
module iir2_par_tb;

  localparam int DW  = 16;
  localparam int CW  = 8;
  localparam int LAT = 3;

  // a = -1 from zero history: x_even, x_odd, y_even, y_odd
  localparam int TBL [4][4] = '{
    '{3, 5, 3, 2},
    '{10, 1, 8, -7},
    '{-4, 0, 3, -3},
    '{100, -50, 103, -153}
  };

  typedef struct {
    int                     stamp;
    logic signed [DW-1:0]   e;
    logic signed [DW-1:0]   o;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b1;
  logic                 flush_i = 1'b0;
  logic                 coef_load_i = 1'b0;
  logic signed [CW-1:0] coef_i = '0;
  logic                 valid_i = 1'b0;
  logic signed [DW-1:0] x_even_i = '0;
  logic signed [DW-1:0] x_odd_i = '0;
  logic                 valid_o;
  logic signed [DW-1:0] y_even_o, y_odd_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string phase = "R1";
  exp_t q[$];
  int ma = 0;
  logic signed [DW-1:0] ry = '0;
  logic signed [DW-1:0] last_e = '0, last_o = '0;

  iir2_par u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .coef_load_i(coef_load_i),
    .coef_i     (coef_i),
    .valid_i    (valid_i),
    .x_even_i   (x_even_i),
    .x_odd_i    (x_odd_i),
    .valid_o    (valid_o),
    .y_even_o   (y_even_o),
    .y_odd_o    (y_odd_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  function automatic logic signed [DW-1:0] w16(input int v);
    return v[DW-1:0];
  endfunction

  task automatic drive(input int x0, input int x1, input int e, input int o);
    exp_t it;
    @(posedge clk); #1;
    valid_i  = 1'b1;
    x_even_i = w16(x0);
    x_odd_i  = w16(x1);
    it.stamp = cyc + LAT;
    it.e     = w16(e);
    it.o     = w16(o);
    q.push_back(it);
  endtask

  // serial reference: one sample per step
  task automatic send(input int x0, input int x1);
    logic signed [DW-1:0] e, o;
    e  = w16(int'(w16(x0)) + ma * int'(ry));
    o  = w16(int'(w16(x1)) + ma * int'(e));
    ry = o;
    drive(x0, x1, e, o);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    valid_i = 1'b0;
  endtask

  task automatic drain();
    repeat (LAT + 2) idle();
  endtask

  task automatic load_coef(input int v);
    @(posedge clk); #1;
    valid_i     = 1'b0;
    coef_load_i = 1'b1;
    coef_i      = v[CW-1:0];
    @(posedge clk); #1;
    coef_load_i = 1'b0;
    ma = v;
  endtask

  // flush edge also carries a pair that must be dropped
  task automatic flush_with_pair(input int x0, input int x1);
    @(posedge clk); #1;
    flush_i  = 1'b1;
    valid_i  = 1'b1;
    x_even_i = w16(x0);
    x_odd_i  = w16(x1);
    @(posedge clk); #1;
    flush_i = 1'b0;
    valid_i = 1'b0;
    q.delete();
    ry = '0;
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", 1, 0);
        end else begin
          exp_t it;
          it = q.pop_front();
          chk(cyc == it.stamp, "R2", cyc, it.stamp);
          chk(y_even_o == it.e, "R3", y_even_o, it.e);
          chk(y_odd_o == it.o, "R4", y_odd_o, it.o);
        end
        last_e = y_even_o;
        last_o = y_odd_o;
      end else begin
        chk(y_even_o == last_e && y_odd_o == last_o, "R10", y_even_o, last_e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1", valid_o, 0);
    chk(y_even_o == 0, "R1", y_even_o, 0);
    chk(y_odd_o == 0, "R1", y_odd_o, 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;

    // R1: zero coefficient after reset, pair passes through
    phase = "R1";
    send(7, -9);
    drain();

    // table walk, a = -1 (R3, R4)
    load_coef(-1);
    flush_with_pair(999, 999);
    phase = "R3_R4_table";
    for (int i = 0; i < 4; i++) begin
      drive(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3]);
      ry = w16(TBL[i][3]);
    end
    drain();

    // R5: contiguous stream against the serial model, a = 2
    phase = "R5";
    load_coef(2);
    for (int i = 0; i < 24; i++)
      send($signed($urandom_range(2000)) - 1000, $signed($urandom_range(2000)) - 1000);

    // R6: idle cycles inside the stream, a = -1
    phase = "R6";
    drain();
    load_coef(-1);
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(2) == 0) idle();
      else send($signed($urandom_range(400)) - 200, $signed($urandom_range(400)) - 200);
    end
    drain();

    // R9: wrap with large samples, a = 3
    phase = "R9";
    load_coef(3);
    flush_with_pair(1, 1);
    for (int i = 0; i < 10; i++)
      send(32000 - i, -32000 + 3 * i);
    drain();

    // R8: flush while pairs are in flight
    phase = "R8";
    load_coef(-2);
    for (int i = 0; i < 5; i++) send(i * 11, -i * 7);
    flush_with_pair(500, 600);
    @(negedge clk);
    chk(valid_o == 1'b0, "R8", valid_o, 0);
    for (int i = 0; i < 3; i++) send(4 + i, 9 - i);
    drain();

    // R7: coefficient change keeps history
    phase = "R7";
    load_coef(1);
    for (int i = 0; i < 6; i++) send(i - 3, 2 * i);
    drain();

    chk(q.size() == 0, "R2", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule